// File: doc/BRIEF.md
# Byte-Block Loopback SPI Target

This block is an SPI target that takes a block of bytes written by an external controller, holds it in an on-chip byte RAM, and returns the same block when the controller reads. The controller chooses the direction with a command byte at the start of each chip-select window. Reads can come back on one line or on two. Write data always arrives on a single line.

The SPI pins are asynchronous to the system clock. They pass through two-flop synchronisers, and the system clock then finds the SCLK edges by oversampling. The link uses mode 0 (SCLK idles low, data is sampled on the rising edge and changed after the falling edge), 8-bit words and MSB first. SCLK must stay at or below one tenth of the system clock, so that every SCLK half period lasts at least five system cycles. The RAM depth is a parameter with a default of 2048 bytes. The address resets to zero on each chip-select assertion and wraps at the depth.

Top module: `spi_lb_slave`

## Requirements
- R1: While cs_ni is high, and after reset, miso_oe_o is 2'b00 (no line driven).
- R2: If the first byte after cs_ni falls is 8'h02, each complete byte that follows is stored at consecutive RAM addresses starting at 0.
- R3: If the first byte after cs_ni falls is 8'h03 and dual mode is off, the stored bytes are returned in order from address 0. Each byte is MSB first on miso_o[0], one bit per SCLK cycle, and is stable at the rising edge. miso_oe_o is 2'b01, and the returned bytes equal the written bytes exactly.
- R4: In dual mode, each read byte goes out as four 2-bit pairs, high pair first. miso_o[1] carries the more significant bit of each pair and miso_oe_o is 2'b11. In this mode write data is still taken from mosi_i on a single line.
- R5: The address wraps at the RAM depth. A write past the end overwrites from address 0, and a read past the end continues from address 0.
- R6: Raising cs_ni ends a transfer at any point, and a partly shifted byte is not stored. The next transfer begins with a command byte at address 0.
- R7: Any other command byte causes the rest of that transfer to be ignored. The RAM is not changed and no MISO line is driven.
- R8: dual_i is captured when the read command byte completes. Changing it later in the same transfer has no effect on the output format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock, idle low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Controller-to-target data |
| dual_i | input | 1 | 1 selects two-line read return |
| miso_o | output | 2 | Target-to-controller data; bit 0 is the single-line output |
| miso_oe_o | output | 2 | Per-line output enable for external tristate buffers |

## Verification
On every cycle, the assertions check four things: outputs are released while chip select is high, the RAM is written only in the write state and the address steps by one per stored byte, a chip-select release returns the engine to the command state at address 0, and an unknown command neither writes nor drives. Other properties need whole scenarios in the bench. These are exact round-trip data in single and dual formats, address wrap on both write and read, dropping of a partial byte on abort, and dual mode being latched at command time. The bench compares them against a byte model that it keeps itself.

// File: rtl/spi_lb_pkg.sv
package spi_lb_pkg;
  localparam int WORD_W = 8;
  localparam logic [WORD_W-1:0] CMD_WRITE = 8'h02;
  localparam logic [WORD_W-1:0] CMD_READ  = 8'h03;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_SKIP
  } lb_state_e;
endpackage

// File: rtl/spi_lb_sync.sv
module spi_lb_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/spi_lb_ram.sv
module spi_lb_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/spi_lb_engine.sv
module spi_lb_engine
  import spi_lb_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_s_i,
  input  logic              mosi_s_i,
  input  logic              dual_s_i,
  output logic              ram_we_o,
  output logic [AW-1:0]     ram_waddr_o,
  output logic [WORD_W-1:0] ram_wdata_o,
  output logic [AW-1:0]     ram_raddr_o,
  input  logic [WORD_W-1:0] ram_rdata_i,
  output logic [1:0]        miso_o,
  output logic [1:0]        miso_oe_o
);
  localparam int CW = $clog2(WORD_W);

  lb_state_e         state_q;
  logic              sclk_d_q;
  logic [WORD_W-2:0] rx_sh_q;
  logic [CW-1:0]     rx_cnt_q;
  logic [AW-1:0]     addr_q;
  logic              dual_q;
  logic [WORD_W-1:0] tx_sh_q;
  logic [CW-1:0]     tx_cnt_q;

  logic              rise, fall, byte_done;
  logic [WORD_W-1:0] rx_byte;

  assign rise      = sclk_s_i & ~sclk_d_q & ~cs_s_i;
  assign fall      = ~sclk_s_i & sclk_d_q & ~cs_s_i;
  assign byte_done = rise && (rx_cnt_q == CW'(WORD_W - 1));
  assign rx_byte   = {rx_sh_q, mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_CMD;
      sclk_d_q <= 1'b0;
      rx_sh_q  <= '0;
      rx_cnt_q <= '0;
      addr_q   <= '0;
      dual_q   <= 1'b0;
      tx_sh_q  <= '0;
      tx_cnt_q <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      if (cs_s_i) begin
        state_q  <= ST_CMD;
        rx_cnt_q <= '0;
        addr_q   <= '0;
        tx_cnt_q <= '0;
      end else begin
        if (rise) begin
          rx_sh_q  <= rx_byte[WORD_W-2:0];
          rx_cnt_q <= rx_cnt_q + 1'b1;
        end
        if (byte_done && state_q == ST_CMD) begin
          if (rx_byte == CMD_WRITE) state_q <= ST_WR;
          else if (rx_byte == CMD_READ) begin
            state_q <= ST_RD;
            dual_q  <= dual_s_i;
          end else state_q <= ST_SKIP;
        end
        if (byte_done && state_q == ST_WR) addr_q <= addr_q + 1'b1;
        // prefetched byte loads on the falling edge that opens a new word
        if (fall && state_q == ST_RD) begin
          if (tx_cnt_q == '0) begin
            tx_sh_q  <= ram_rdata_i;
            addr_q   <= addr_q + 1'b1;
            tx_cnt_q <= dual_q ? CW'(WORD_W / 2 - 1) : CW'(WORD_W - 1);
          end else begin
            tx_sh_q  <= dual_q ? {tx_sh_q[WORD_W-3:0], 2'b00} : {tx_sh_q[WORD_W-2:0], 1'b0};
            tx_cnt_q <= tx_cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign ram_we_o    = byte_done && state_q == ST_WR;
  assign ram_waddr_o = addr_q;
  assign ram_wdata_o = rx_byte;
  assign ram_raddr_o = addr_q;

  assign miso_o    = dual_q ? tx_sh_q[WORD_W-1 -: 2] : {1'b0, tx_sh_q[WORD_W-1]};
  assign miso_oe_o = (state_q == ST_RD) ? (dual_q ? 2'b11 : 2'b01) : 2'b00;

  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> miso_oe_o == 2'b00);
  p_write_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> state_q == ST_WR);
  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && !cs_s_i) |=> addr_q == $past(addr_q) + 1'b1);
  p_cs_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_s_i) |=> (addr_q == '0 && state_q == ST_CMD));
  p_skip_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SKIP |-> (!ram_we_o && miso_oe_o == 2'b00));
endmodule

// File: rtl/spi_lb_slave.sv
module spi_lb_slave
  import spi_lb_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic       dual_i,
  output logic [1:0] miso_o,
  output logic [1:0] miso_oe_o
);
  logic [3:0]        pins_s;
  logic              ram_we;
  logic [AW-1:0]     ram_waddr, ram_raddr;
  logic [WORD_W-1:0] ram_wdata, ram_rdata;

  spi_lb_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dual_i, cs_ni, mosi_i, sclk_i}),
    .q_o   (pins_s)
  );

  spi_lb_engine #(.DEPTH(DEPTH)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (pins_s[0]),
    .cs_s_i     (pins_s[2]),
    .mosi_s_i   (pins_s[1]),
    .dual_s_i   (pins_s[3]),
    .ram_we_o   (ram_we),
    .ram_waddr_o(ram_waddr),
    .ram_wdata_o(ram_wdata),
    .ram_raddr_o(ram_raddr),
    .ram_rdata_i(ram_rdata),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o)
  );

  spi_lb_ram #(.DEPTH(DEPTH), .DW(WORD_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .waddr_i(ram_waddr),
    .wdata_i(ram_wdata),
    .raddr_i(ram_raddr),
    .rdata_o(ram_rdata)
  );
endmodule

// File: tb/tb_spi_lb_slave.sv
module tb_spi_lb_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 5;
  localparam int DEPTH      = 64;
  localparam int TIMEOUT    = 190000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, dual = 1'b0;
  logic [1:0] miso, miso_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_lb_slave #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n),
    .mosi_i(mosi), .dual_i(dual), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCLK cycle in mode 0; returns MISO just before the rising edge
  task automatic sclk_cycle(input logic b, output logic [1:0] smp);
    mosi = b;
    wait_sys(HALF);
    smp = miso;
    sclk = 1'b1;
    wait_sys(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic [1:0] s;
    for (int i = 7; i >= 0; i--) sclk_cycle(v[i], s);
  endtask

  task automatic recv_byte(input bit two, output logic [7:0] v);
    logic [1:0] s;
    v = '0;
    if (two) for (int i = 0; i < 4; i++) begin sclk_cycle(1'b0, s); v = {v[5:0], s}; end
    else     for (int i = 0; i < 8; i++) begin sclk_cycle(1'b0, s); v = {v[6:0], s[0]}; end
  endtask

  task automatic begin_xfer(input logic [7:0] cmd);
    cs_n = 1'b0;
    wait_sys(4);
    send_byte(cmd);
  endtask

  task automatic end_xfer();
    wait_sys(3);
    cs_n = 1'b1;
    wait_sys(8);
  endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * (2 * seed + 1) + seed * 29 + 7) ^ (k >> 3));
  endfunction

  task automatic write_block(input int n, input int seed);
    begin_xfer(8'h02);
    for (int k = 0; k < n; k++) begin
      send_byte(pat(k, seed));
      model[k % DEPTH] = pat(k, seed);
    end
    end_xfer();
  endtask

  task automatic read_block(input int n, input bit two, input string req);
    logic [7:0] v;
    int bad = 0;
    dual = two;
    begin_xfer(8'h03);
    for (int k = 0; k < n; k++) begin
      recv_byte(two, v);
      if (k == 0) check(miso_oe == (two ? 2'b11 : 2'b01), req, miso_oe, two ? 3 : 1);
      if (v !== model[k % DEPTH]) begin
        bad++;
        check(1'b0, req, v, model[k % DEPTH]);
      end
    end
    check(bad == 0, req, bad, 0);
    end_xfer();
    dual = 1'b0;
    check(miso_oe == 2'b00, "R1", miso_oe, 0);
  endtask

  initial begin
    #(CLK_PERIOD * TIMEOUT);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [1:0] s;
    wait_sys(4);
    check(miso_oe == 2'b00, "R1", miso_oe, 0);
    rst_ni = 1'b1;
    wait_sys(4);
    check(miso_oe == 2'b00, "R1", miso_oe, 0);

    // R2 R3: full block, single-line return
    write_block(DEPTH, 1);
    read_block(DEPTH, 1'b0, "R3");
    // R4: dual-line return of the same block
    read_block(DEPTH, 1'b1, "R4");
    // R4: write with dual_i high still takes single-line data
    dual = 1'b1;
    write_block(DEPTH, 2);
    dual = 1'b0;
    read_block(DEPTH, 1'b0, "R4");
    read_block(DEPTH, 1'b1, "R4");

    // R5: write past the end overwrites the low addresses, read wraps
    write_block(DEPTH + 3, 3);
    read_block(DEPTH + 5, 1'b0, "R5");

    // R6: abort mid-byte; completed bytes stored, partial dropped
    begin_xfer(8'h02);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'hC0 + 8'(k));
      model[k] = 8'hC0 + 8'(k);
    end
    for (int i = 0; i < 4; i++) sclk_cycle(1'b1, s);
    end_xfer();
    check(miso_oe == 2'b00, "R6", miso_oe, 0);
    // abort a read after two bytes, then restart from zero
    begin_xfer(8'h03);
    recv_byte(1'b0, v);
    check(v == model[0], "R6", v, model[0]);
    recv_byte(1'b0, v);
    end_xfer();
    read_block(8, 1'b0, "R6");

    // R7: unknown command leaves RAM and MISO untouched
    begin_xfer(8'h5A);
    for (int k = 0; k < 6; k++) begin
      send_byte(8'hFF);
      check(miso_oe == 2'b00, "R7", miso_oe, 0);
    end
    end_xfer();
    begin_xfer(8'h00);
    send_byte(8'h02);
    send_byte(8'h11);
    end_xfer();
    read_block(DEPTH, 1'b0, "R7");

    // R8: dual_i raised after the read command has no effect
    dual = 1'b0;
    begin_xfer(8'h03);
    dual = 1'b1;
    for (int k = 0; k < 4; k++) begin
      recv_byte(1'b0, v);
      check(v == model[k], "R8", v, model[k]);
    end
    check(miso_oe == 2'b01, "R8", miso_oe, 1);
    end_xfer();
    dual = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule